// File: doc/BRIEF.md
# Signature-Based Transactional Conflict Tracker

This block sits next to a core's private cache controller and records which remote cores a running transaction has collided with. Every transactional load and store address is folded into one of two Bloom-filter signatures (one for reads, one for writes). The filters are conservative: they may claim that an address was touched when it was not, but they never miss an address that was really inserted. When the directory forwards a coherence request from another core, the block tests the request's line address against both filters. From the two hit bits and the request type it picks the conflict response that goes back to the requester. It also signals when a non-transactional exclusive request must abort the local transaction.

Conflicts are kept per remote core, not per cache line, in three bit-vectors named here read-write, write-read and write-write. A bit is set on the responding side when the block answers a forwarded request with a conflict. A bit is also set on the requesting side when the block's own transactional access comes back with a conflict response. Software can read the write-read and write-write vectors and clear them in one atomic step. An abort empties both filters and all three vectors. In eager mode, a conflict response to the core's own request raises a one-cycle trap that carries a programmable handler address. In lazy mode only the vectors are updated.

Top module: `conflict_tracker`

## Requirements
- R1: A transactional access (`acc_valid`) inserts its address into the read filter when `acc_store`=0 and into the write filter when `acc_store`=1. The line number is the address shifted right by `OFFSET_W` (6). The filter sets two bits: index A = line[10:0] and index B = line[10:0] XOR line[21:11]. A filter hits when both indexed bits are set. The insertion is visible from the next cycle.
- R2: A filter never reports a miss for a line inserted since the last reset or abort.
- R3: For a forwarded request (`fwd_valid`) that hits the write filter, `fwd_resp` is 4 (conflict on a remote write), whatever the request type.
- R4: On a write-filter miss with a read-filter hit, the response depends on the request type: GETS (`fwd_type`=0) gives 1 (shared), GETX (1) gives 2 (invalidated) and TGETX (2) gives 3 (exposed read). A miss in both filters gives 0 (plain coherence). With no forwarded request, `fwd_resp` is 0.
- R5: When responding, the block sets the bit for `fwd_src` at the next clock edge. A write-filter hit against GETS sets write-read. A write-filter hit against TGETX sets write-write. A read-filter-only hit against TGETX sets read-write. No other case changes a vector.
- R6: When a response to the core's own request arrives (`rsp_valid`), the block sets the bit for `rsp_src` at the next clock edge. A load (`rsp_store`=0) that gets code 4 sets read-write. A store that gets code 4 sets write-write. A store that gets code 3 sets write-read. The bit for the core's own id `MY_ID` is never set.
- R7: While `cc_req` is high, `wr_vec` and `ww_vec` show their current contents, and both vectors are cleared at the clock edge. A bit set in that same cycle survives the clear. `rw_vec` is not affected.
- R8: In eager mode (`eager_mode`=1), a response with code 4 or 3 raises `trap_valid` for the next cycle, with `trap_pc` equal to the `handler_pc` value sampled with that response. In lazy mode `trap_valid` stays low.
- R9: `must_abort` is high exactly when a forwarded GETX hits either filter.
- R10: `abort_clr` empties both filters, clears all three vectors and suppresses the trap at the clock edge. It takes priority over any insertion or bit set in the same cycle.
- R11: After reset, both filters are empty, all vectors are zero and `trap_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eager_mode | input | 1 | 1 = eager conflict trap, 0 = lazy |
| handler_pc | input | PC_W | Conflict handler address |
| acc_valid | input | 1 | Transactional access insert strobe |
| acc_store | input | 1 | 1 = store (write filter), 0 = load (read filter) |
| acc_addr | input | ADDR_W | Byte address of the access |
| fwd_valid | input | 1 | Forwarded remote request present |
| fwd_type | input | 2 | 0 GETS, 1 GETX, 2 TGETX |
| fwd_src | input | CID_W | Requesting core id |
| fwd_addr | input | ADDR_W | Byte address of the forwarded request |
| fwd_resp | output | 3 | Response code 0..4 |
| must_abort | output | 1 | Local transaction must abort |
| rsp_valid | input | 1 | Response to own request present |
| rsp_store | input | 1 | Own request was a transactional store |
| rsp_code | input | 3 | Received response code |
| rsp_src | input | CID_W | Responding core id |
| cc_req | input | 1 | Copy-and-clear of write-read and write-write |
| abort_clr | input | 1 | Abort clear |
| rw_vec | output | NCORES | Read-write summary |
| wr_vec | output | NCORES | Write-read summary |
| ww_vec | output | NCORES | Write-write summary |
| trap_valid | output | 1 | Eager conflict trap |
| trap_pc | output | PC_W | Trap handler address |

## Verification
The assertions assume that `fwd_type` never takes the reserved value 3 and that the core ids fit below `NCORES`. They also assume that a response code of 1 or 2 never arrives on `rsp_code` together with a transactional load that expects a conflict. The stimulus draws the request type only from 0 to 2 and the core ids only from the valid range. It takes addresses from a small pool so that filter hits are frequent. It raises abort often enough that the filters do not saturate into permanent hits.

// File: rtl/ct_pkg.sv
package ct_pkg;
   typedef enum logic [1:0] {
      REQ_GETS  = 2'd0,
      REQ_GETX  = 2'd1,
      REQ_TGETX = 2'd2
   } req_e;

   typedef enum logic [2:0] {
      RSP_PLAIN  = 3'd0,
      RSP_SHARED = 3'd1,
      RSP_INVAL  = 3'd2,
      RSP_EXPRD  = 3'd3,
      RSP_THREAT = 3'd4
   } rsp_e;
endpackage

// File: rtl/ct_bloom.sv
module ct_bloom #(
   parameter int ADDR_W   = 32,
   parameter int SIG_BITS = 2048,
   parameter int OFFSET_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_hit
);
   localparam int IDX_W  = $clog2(SIG_BITS);
   localparam int LINE_W = ADDR_W - OFFSET_W;

   if (SIG_BITS != (1 << IDX_W)) begin : g_bad_size
      $error("ct_bloom: SIG_BITS must be a power of two");
   end
   if (LINE_W < 2 * IDX_W) begin : g_bad_line
      $error("ct_bloom: line number too narrow for two hash fields");
   end

   function automatic logic [IDX_W-1:0] hash_a(input logic [ADDR_W-1:0] a);
      logic [LINE_W-1:0] ln;
      ln = a[ADDR_W-1:OFFSET_W];
      return ln[IDX_W-1:0];
   endfunction

   function automatic logic [IDX_W-1:0] hash_b(input logic [ADDR_W-1:0] a);
      logic [LINE_W-1:0] ln;
      ln = a[ADDR_W-1:OFFSET_W];
      return ln[IDX_W-1:0] ^ ln[2*IDX_W-1:IDX_W];
   endfunction

   logic [SIG_BITS-1:0] bits_q;
   logic [IDX_W-1:0]    ia, ib;

   assign ia    = hash_a(ins_addr);
   assign ib    = hash_b(ins_addr);
   assign q_hit = bits_q[hash_a(q_addr)] & bits_q[hash_b(q_addr)];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         bits_q <= '0;
      end else if (ins_valid) begin
         bits_q[ia] <= 1'b1;
         bits_q[ib] <= 1'b1;
      end
   end

   // R1 / R2: an inserted line is a member from the next cycle on
   a_r2_inserted_member: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && !clr |=> bits_q[$past(ia)] && bits_q[$past(ib)]);
   // R10: clear empties the filter
   a_r10_filter_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> bits_q == '0);
endmodule

// File: rtl/ct_classify.sv
module ct_classify
   import ct_pkg::*;
(
   input  logic       fwd_valid,
   input  logic [1:0] fwd_type,
   input  logic       w_hit,
   input  logic       r_hit,
   output logic [2:0] resp,
   output logic       set_rw,
   output logic       set_wr,
   output logic       set_ww,
   output logic       abort_req
);
   req_e rq;
   assign rq = req_e'(fwd_type);

   always_comb begin
      resp = RSP_PLAIN;
      if (fwd_valid) begin
         if (w_hit) begin
            resp = RSP_THREAT;
         end else if (r_hit) begin
            unique case (rq)
               REQ_GETX:  resp = RSP_INVAL;
               REQ_TGETX: resp = RSP_EXPRD;
               default:   resp = RSP_SHARED;
            endcase
         end
      end
   end

   assign set_wr    = fwd_valid &&  w_hit && (rq == REQ_GETS);
   assign set_ww    = fwd_valid &&  w_hit && (rq == REQ_TGETX);
   assign set_rw    = fwd_valid && !w_hit && r_hit && (rq == REQ_TGETX);
   assign abort_req = fwd_valid && (w_hit || r_hit) && (rq == REQ_GETX);
endmodule

// File: rtl/ct_summary.sv
module ct_summary
   import ct_pkg::*;
#(
   parameter int NCORES = 4,
   parameter int MY_ID  = 0,
   localparam int CID_W = $clog2(NCORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cc_req,
   input  logic              set_rw,
   input  logic              set_wr,
   input  logic              set_ww,
   input  logic [CID_W-1:0]  fwd_src,
   input  logic              rsp_valid,
   input  logic              rsp_store,
   input  logic [2:0]        rsp_code,
   input  logic [CID_W-1:0]  rsp_src,
   output logic [NCORES-1:0] rw_q,
   output logic [NCORES-1:0] wr_q,
   output logic [NCORES-1:0] ww_q
);
   if (NCORES < 2) begin : g_bad_cores
      $error("ct_summary: at least two cores required");
   end
   if (MY_ID >= NCORES) begin : g_bad_id
      $error("ct_summary: MY_ID out of range");
   end

   localparam logic [NCORES-1:0] OWN = NCORES'(1) << MY_ID;

   logic [NCORES-1:0] oh_fwd, oh_rsp;
   logic              got_thr, got_exp;

   assign oh_fwd  = (NCORES'(1) << fwd_src) & ~OWN;
   assign oh_rsp  = (NCORES'(1) << rsp_src) & ~OWN;
   assign got_thr = rsp_valid && (rsp_e'(rsp_code) == RSP_THREAT);
   assign got_exp = rsp_valid && (rsp_e'(rsp_code) == RSP_EXPRD);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         rw_q <= '0;
         wr_q <= '0;
         ww_q <= '0;
      end else begin
         rw_q <= rw_q
               | (set_rw ? oh_fwd : '0)
               | ((got_thr && !rsp_store) ? oh_rsp : '0);
         wr_q <= (cc_req ? '0 : wr_q)
               | (set_wr ? oh_fwd : '0)
               | ((got_exp && rsp_store) ? oh_rsp : '0);
         ww_q <= (cc_req ? '0 : ww_q)
               | (set_ww ? oh_fwd : '0)
               | ((got_thr && rsp_store) ? oh_rsp : '0);
      end
   end

   // R6: own core bit never recorded
   a_r6_own_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((rw_q | wr_q | ww_q) & OWN) == '0);
   // R7: copy-and-clear never drops read-write bits
   a_r7_rw_kept: assert property (@(posedge clk) disable iff (!rst_n)
      cc_req && !clr |=> (rw_q & $past(rw_q)) == $past(rw_q));
   // R6: without clear, write-write bits are sticky
   a_r6_ww_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_req && !clr |=> (ww_q & $past(ww_q)) == $past(ww_q));
   // R10: abort empties every vector
   a_r10_vectors_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rw_q | wr_q | ww_q) == '0);
endmodule

// File: rtl/conflict_tracker.sv
module conflict_tracker
   import ct_pkg::*;
#(
   parameter int NCORES   = 4,
   parameter int MY_ID    = 0,
   parameter int ADDR_W   = 32,
   parameter int SIG_BITS = 2048,
   parameter int OFFSET_W = 6,
   parameter int PC_W     = 32,
   localparam int CID_W   = $clog2(NCORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eager_mode,
   input  logic [PC_W-1:0]   handler_pc,
   input  logic              acc_valid,
   input  logic              acc_store,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              fwd_valid,
   input  logic [1:0]        fwd_type,
   input  logic [CID_W-1:0]  fwd_src,
   input  logic [ADDR_W-1:0] fwd_addr,
   output logic [2:0]        fwd_resp,
   output logic              must_abort,
   input  logic              rsp_valid,
   input  logic              rsp_store,
   input  logic [2:0]        rsp_code,
   input  logic [CID_W-1:0]  rsp_src,
   input  logic              cc_req,
   input  logic              abort_clr,
   output logic [NCORES-1:0] rw_vec,
   output logic [NCORES-1:0] wr_vec,
   output logic [NCORES-1:0] ww_vec,
   output logic              trap_valid,
   output logic [PC_W-1:0]   trap_pc
);
   logic [1:0] hit;   // [0] read filter, [1] write filter
   logic       s_rw, s_wr, s_ww;

   for (genvar g = 0; g < 2; g++) begin : g_sig
      ct_bloom #(.ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .OFFSET_W(OFFSET_W)) i_bloom (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (abort_clr),
         .ins_valid (acc_valid && (acc_store == (g == 1))),
         .ins_addr  (acc_addr),
         .q_addr    (fwd_addr),
         .q_hit     (hit[g])
      );
   end

   ct_classify i_classify (
      .fwd_valid (fwd_valid),
      .fwd_type  (fwd_type),
      .w_hit     (hit[1]),
      .r_hit     (hit[0]),
      .resp      (fwd_resp),
      .set_rw    (s_rw),
      .set_wr    (s_wr),
      .set_ww    (s_ww),
      .abort_req (must_abort)
   );

   ct_summary #(.NCORES(NCORES), .MY_ID(MY_ID)) i_summary (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (abort_clr),
      .cc_req    (cc_req),
      .set_rw    (s_rw),
      .set_wr    (s_wr),
      .set_ww    (s_ww),
      .fwd_src   (fwd_src),
      .rsp_valid (rsp_valid),
      .rsp_store (rsp_store),
      .rsp_code  (rsp_code),
      .rsp_src   (rsp_src),
      .rw_q      (rw_vec),
      .wr_q      (wr_vec),
      .ww_q      (ww_vec)
   );

   logic conflict_in;
   assign conflict_in = rsp_valid && (rsp_e'(rsp_code) == RSP_THREAT || rsp_e'(rsp_code) == RSP_EXPRD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_valid <= 1'b0;
         trap_pc    <= '0;
      end else begin
         trap_valid <= eager_mode && conflict_in && !abort_clr;
         if (eager_mode && conflict_in && !abort_clr) trap_pc <= handler_pc;
      end
   end

   // R3: write-filter hit always answers with the remote-write conflict code
   a_r3_write_hit_threat: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid && hit[1] |-> fwd_resp == 3'd4);
   // R9: abort request only for exclusive non-transactional requests
   a_r9_abort_on_getx: assert property (@(posedge clk) disable iff (!rst_n)
      must_abort |-> fwd_valid && fwd_type == 2'd1 && (hit != 2'b00));
   // R8: eager conflict raises trap with sampled handler
   a_r8_eager_trap: assert property (@(posedge clk) disable iff (!rst_n)
      eager_mode && conflict_in && !abort_clr |=> trap_valid && trap_pc == $past(handler_pc));
   // R8: lazy mode never traps
   a_r8_lazy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !eager_mode |=> !trap_valid);
endmodule

// File: tb/test_conflict_tracker.sv
module test_conflict_tracker;
   localparam int NC = 4;
   localparam int ME = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eager_mode = 1'b0;
   logic [31:0] handler_pc = '0;
   logic        acc_valid = 1'b0, acc_store = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        fwd_valid = 1'b0;
   logic [1:0]  fwd_type = '0;
   logic [1:0]  fwd_src = '0;
   logic [31:0] fwd_addr = '0;
   logic [2:0]  fwd_resp;
   logic        must_abort;
   logic        rsp_valid = 1'b0, rsp_store = 1'b0;
   logic [2:0]  rsp_code = '0;
   logic [1:0]  rsp_src = '0;
   logic        cc_req = 1'b0, abort_clr = 1'b0;
   logic [3:0]  rw_vec, wr_vec, ww_vec;
   logic        trap_valid;
   logic [31:0] trap_pc;

   always #5 clk = ~clk;

   conflict_tracker i_conflict_tracker (.*);

   // reference model state
   bit          rs[2048];
   bit          ws[2048];
   logic [3:0]  m_rw, m_wr, m_ww;
   logic        m_trap;
   logic [31:0] m_tpc;
   int          checks = 0, errors = 0;
   string       cur_tag = "R11";

   function automatic int ha(logic [31:0] a);
      return int'((a >> 6) & 32'h7ff);
   endfunction
   function automatic int hb(logic [31:0] a);
      return int'(((a >> 6) & 32'h7ff) ^ ((a >> 17) & 32'h7ff));
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      foreach (rs[i]) rs[i] = 1'b0;
      foreach (ws[i]) ws[i] = 1'b0;
      m_rw = '0; m_wr = '0; m_ww = '0; m_trap = 1'b0; m_tpc = '0;
   endtask

   // one cycle: inputs set by caller at negedge; compare, clock, update model
   task automatic tick();
      bit        wh, rh;
      logic [2:0] er;
      logic [3:0] ohf, ohr, nrw, nwr, nww;
      wh = ws[ha(fwd_addr)] && ws[hb(fwd_addr)];
      rh = rs[ha(fwd_addr)] && rs[hb(fwd_addr)];
      er = 3'd0;
      if (fwd_valid) begin
         if (wh) er = 3'd4;
         else if (rh) er = (fwd_type == 2'd1) ? 3'd2 : (fwd_type == 2'd2) ? 3'd3 : 3'd1;
      end
      #3;
      check(wh ? "R3 fwd_resp" : "R4 fwd_resp", 64'(fwd_resp), 64'(er));
      check("R9 must_abort", 64'(must_abort), 64'(fwd_valid && fwd_type == 2'd1 && (wh || rh)));
      check({cur_tag, " rw_vec"}, 64'(rw_vec), 64'(m_rw));
      check({cur_tag, " wr_vec"}, 64'(wr_vec), 64'(m_wr));
      check({cur_tag, " ww_vec"}, 64'(ww_vec), 64'(m_ww));
      check("R8 trap_valid", 64'(trap_valid), 64'(m_trap));
      if (m_trap) check("R8 trap_pc", 64'(trap_pc), 64'(m_tpc));
      @(posedge clk);
      ohf = (4'b1 << fwd_src) & ~(4'b1 << ME);
      ohr = (4'b1 << rsp_src) & ~(4'b1 << ME);
      if (abort_clr) begin
         model_reset();
      end else begin
         nrw = m_rw; nwr = cc_req ? 4'b0 : m_wr; nww = cc_req ? 4'b0 : m_ww;
         if (fwd_valid && wh && fwd_type == 2'd0) nwr |= ohf;
         if (fwd_valid && wh && fwd_type == 2'd2) nww |= ohf;
         if (fwd_valid && !wh && rh && fwd_type == 2'd2) nrw |= ohf;
         if (rsp_valid && rsp_code == 3'd4 && !rsp_store) nrw |= ohr;
         if (rsp_valid && rsp_code == 3'd4 && rsp_store) nww |= ohr;
         if (rsp_valid && rsp_code == 3'd3 && rsp_store) nwr |= ohr;
         m_rw = nrw; m_wr = nwr; m_ww = nww;
         m_trap = eager_mode && rsp_valid && (rsp_code == 3'd4 || rsp_code == 3'd3);
         if (m_trap) m_tpc = handler_pc;
         if (acc_valid) begin
            if (acc_store) begin ws[ha(acc_addr)] = 1'b1; ws[hb(acc_addr)] = 1'b1; end
            else begin rs[ha(acc_addr)] = 1'b1; rs[hb(acc_addr)] = 1'b1; end
         end
      end
      @(negedge clk);
      acc_valid = 0; fwd_valid = 0; rsp_valid = 0; cc_req = 0; abort_clr = 0;
   endtask

   task automatic do_acc(input logic st, input logic [31:0] a);
      acc_valid = 1; acc_store = st; acc_addr = a; tick();
   endtask
   task automatic do_fwd(input logic [1:0] t, input logic [1:0] s, input logic [31:0] a);
      fwd_valid = 1; fwd_type = t; fwd_src = s; fwd_addr = a; tick();
   endtask
   task automatic do_rsp(input logic st, input logic [2:0] c, input logic [1:0] s);
      rsp_valid = 1; rsp_store = st; rsp_code = c; rsp_src = s; tick();
   endtask

   localparam logic [31:0] A = 32'h0000_1040;
   localparam logic [31:0] B = 32'h0002_3080;
   localparam logic [31:0] C = 32'h0055_5500;

   bit done = 0;

   initial begin
      logic [31:0] pool[8];
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      cur_tag = "R11";
      tick();
      // R1: inserts, then R4 / R3 classification and R5 responder updates
      cur_tag = "R1";
      do_acc(0, A);
      do_acc(1, B);
      do_acc(0, A + 32'h3f);            // same line, same bits
      cur_tag = "R4";
      do_fwd(2'd0, 2'd1, A);             // shared
      do_fwd(2'd1, 2'd2, A + 32'h10);    // invalidated, abort (R9)
      do_fwd(2'd0, 2'd3, C);             // plain
      cur_tag = "R5";
      do_fwd(2'd2, 2'd1, A);             // exposed read -> rw[1]
      do_fwd(2'd0, 2'd2, B);             // threat -> wr[2]
      do_fwd(2'd2, 2'd3, B);             // threat -> ww[3]
      do_fwd(2'd1, 2'd3, B);             // threat, abort, no bit
      do_fwd(2'd2, 2'd0, B);             // own id, no bit
      // R6 requester side and R8 trap
      cur_tag = "R6";
      eager_mode = 1; handler_pc = 32'hdead_0100;
      do_rsp(0, 3'd4, 2'd2);             // rw[2], trap
      handler_pc = 32'hbeef_0200;
      do_rsp(1, 3'd3, 2'd1);             // wr[1], trap
      do_rsp(1, 3'd1, 2'd2);             // no effect
      do_rsp(1, 3'd4, 2'd0);             // own id, trap only
      cur_tag = "R8";
      eager_mode = 0;
      do_rsp(1, 3'd4, 2'd2);             // ww[2], no trap
      tick();
      // R7 copy-and-clear with same-cycle set
      cur_tag = "R7";
      cc_req = 1; fwd_valid = 1; fwd_type = 2'd2; fwd_src = 2'd1; fwd_addr = B;
      tick();
      tick();
      // R10 abort wins over same-cycle insert and trap
      cur_tag = "R10";
      eager_mode = 1;
      abort_clr = 1; acc_valid = 1; acc_store = 1; acc_addr = C;
      rsp_valid = 1; rsp_store = 1; rsp_code = 3'd4; rsp_src = 2'd3;
      tick();
      do_fwd(2'd2, 2'd1, C);
      do_fwd(2'd0, 2'd1, B);
      // R2: random traffic from a small pool
      cur_tag = "R2";
      foreach (pool[i]) pool[i] = $urandom;
      for (int n = 0; n < 3000; n++) begin
         eager_mode = $urandom_range(0, 1);
         handler_pc = $urandom;
         acc_valid = ($urandom_range(0, 2) == 0);
         acc_store = $urandom_range(0, 1);
         acc_addr = pool[$urandom_range(0, 7)];
         fwd_valid = $urandom_range(0, 1);
         fwd_type = 2'($urandom_range(0, 2));
         fwd_src = 2'($urandom_range(0, 3));
         fwd_addr = ($urandom_range(0, 3) == 0) ? $urandom : pool[$urandom_range(0, 7)];
         rsp_valid = ($urandom_range(0, 2) == 0);
         rsp_store = $urandom_range(0, 1);
         rsp_code = 3'($urandom_range(0, 4));
         rsp_src = 2'($urandom_range(0, 3));
         cc_req = ($urandom_range(0, 9) == 0);
         abort_clr = ($urandom_range(0, 39) == 0);
         tick();
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule